// File: doc/BRIEF.md
# Dual-Path ADC Trigger Delay Controller

This block times ADC conversion starts relative to an external start event. A single up-counter starts on the event and counts from zero to a programmed modulus. Each of four channels compares the counter against two private delay values. On a match the channel issues a one-cycle trigger on its path A or path B. The two paths select different result register sets in the ADC they drive. The counter either stops after the wrap to wait for a new event, or restarts at once when continuous mode is on.

The two paths of a channel are interlocked. After a channel issues a trigger on one path, that conversion is in flight until the ADC returns that path's conversion-complete strobe. While it is in flight, a delay match on the other path is dropped and is not issued later. Instead, the channel latches a sequence error for the dropped path. Software clears the error flags by writing ones. Any set flag drives a single interrupt line that has no mask.

Configuration uses a simple write port: write enable, address and data. All writes take effect on the following cycle.

Top module: `adc_trig_delay_top`

## Requirements
- R1: The counter is idle after reset. A start event seen while idle makes the counter run from 0, adding 1 each cycle. When the count equals the modulus, the next value is 0. In one-shot mode the counter then goes idle and produces no further triggers until a new start event.
- R2: In continuous mode (control bit 0 = 1) the counter keeps running after the wrap, so the triggers repeat every modulus+1 cycles.
- R3: A start event that arrives while the counter is running has no effect on the counter or on the trigger timing.
- R4: `trig_a[n]` is high for one cycle on the rising edge that follows a cycle in which the running count equals channel n's delay A. That is the (delay+2)-th edge, counting the edge that samples `start_evt` as the first. A delay larger than the modulus never fires.
- R5: `trig_b[n]` follows the same timing rule using channel n's delay B.
- R6: Path A of a channel is in flight from its `trig_a` edge until `conv_done_a[n]` is sampled high. While it is in flight, a delay-B match issues no `trig_b[n]`. The dropped trigger is not issued later.
- R7: In the same way, a delay-A match issues no `trig_a[n]` while path B is in flight (from `trig_b[n]` until `conv_done_b[n]`).
- R8: A dropped delay-B match sets `err_b[n]` on the same edge where the trigger would have risen. A dropped delay-A match sets `err_a[n]` in the same way.
- R9: Error flags stay set until a write to address 2*NCH+2 carries a 1 in bit n (clears `err_a[n]`) or in bit NCH+n (clears `err_b[n]`). If a new error and a clear for the same flag happen in the same cycle, the flag stays set.
- R10: `seq_irq` is high exactly when any `err_a` or `err_b` bit is high. No enable or mask exists.
- R11: After synchronous reset, all outputs are low, the counter is idle, nothing is in flight, and every configuration value is zero.
- R12: Configuration address map: address 0, bit 0 selects continuous mode; address 1 holds the modulus; address 2+2n holds delay A of channel n; address 3+2n holds delay B of channel n. A write takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | AW | Configuration address |
| cfg_wdata | input | CW | Configuration write data |
| start_evt | input | 1 | External start event |
| conv_done_a | input | NCH | Per-channel path A conversion complete |
| conv_done_b | input | NCH | Per-channel path B conversion complete |
| trig_a | output | NCH | Per-channel path A trigger pulse |
| trig_b | output | NCH | Per-channel path B trigger pulse |
| err_a | output | NCH | Per-channel path A sequence error flag |
| err_b | output | NCH | Per-channel path B sequence error flag |
| seq_irq | output | 1 | Combined sequence error interrupt |

## Verification
The hardest case to reach from the ports is a new sequence error that lands in the same cycle as a software clear of that same flag. The bench first stretches conversion latency so that path A is still in flight when delay B matches. It then watches its reference model's count and issues the clear write in the exact cycle before the blocked match. Other phases cover dropped triggers in both directions, a start event ignored while running, continuous wrap, and a delay past the modulus. Conversion-complete strobes come from a latency responder driven by the model.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  // Fixed address slots below the per-channel delay block
  localparam int unsigned SLOT_CTRL    = 0;
  localparam int unsigned SLOT_MODULUS = 1;
  localparam int unsigned SLOT_DLY0    = 2;

  function automatic int unsigned errclr_slot(input int unsigned nch);
    return SLOT_DLY0 + 2 * nch;
  endfunction
endpackage

// File: rtl/trig_counter.sv
module trig_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cont,
  input  logic [CW-1:0] modulus,
  output logic          running,
  output logic [CW-1:0] count
);
  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      if (start) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end
    end else if (cnt_q == modulus) begin
      cnt_q <= '0;
      run_q <= cont;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign running = run_q;
  assign count   = cnt_q;

  // R1: wrap returns to zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q == modulus) |=> (cnt_q == '0));
  // R1: one-shot stops after wrap
  p_stop_r1: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q == modulus && !cont) |=> !run_q);
  // R2: continuous keeps running
  p_cont_r2: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q == modulus && cont) |=> run_q);
  // R3: start while running leaves the count advancing normally
  p_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    (run_q && start && cnt_q != modulus) |=> (run_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/trig_channel.sv
module trig_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          running,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] dly_a,
  input  logic [CW-1:0] dly_b,
  input  logic          done_a,
  input  logic          done_b,
  input  logic          clr_a,
  input  logic          clr_b,
  output logic          trig_a,
  output logic          trig_b,
  output logic          err_a,
  output logic          err_b
);
  logic hit_a, hit_b, fire_a, fire_b;
  logic infl_a_q, infl_b_q, trig_a_q, trig_b_q, err_a_q, err_b_q;

  always_comb begin
    hit_a  = running && (count == dly_a);
    hit_b  = running && (count == dly_b);
    fire_a = hit_a && !infl_b_q;
    fire_b = hit_b && !infl_a_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_a_q <= 1'b0;
      trig_b_q <= 1'b0;
      infl_a_q <= 1'b0;
      infl_b_q <= 1'b0;
      err_a_q  <= 1'b0;
      err_b_q  <= 1'b0;
    end else begin
      trig_a_q <= fire_a;
      trig_b_q <= fire_b;
      infl_a_q <= fire_a | (infl_a_q & ~done_a);
      infl_b_q <= fire_b | (infl_b_q & ~done_b);
      err_a_q  <= (hit_a & infl_b_q) | (err_a_q & ~clr_a);
      err_b_q  <= (hit_b & infl_a_q) | (err_b_q & ~clr_b);
    end
  end

  assign trig_a = trig_a_q;
  assign trig_b = trig_b_q;
  assign err_a  = err_a_q;
  assign err_b  = err_b_q;

  // R6 / R8: B match during A conversion is dropped and flagged
  p_block_b_r6: assert property (@(posedge clk) disable iff (rst)
    (infl_a_q && hit_b) |=> (!trig_b_q && err_b_q));
  // R7 / R8: A match during B conversion is dropped and flagged
  p_block_a_r7: assert property (@(posedge clk) disable iff (rst)
    (infl_b_q && hit_a) |=> (!trig_a_q && err_a_q));
  // R9: flags hold without a clear
  p_sticky_a_r9: assert property (@(posedge clk) disable iff (rst)
    (err_a_q && !clr_a) |=> err_a_q);
  p_sticky_b_r9: assert property (@(posedge clk) disable iff (rst)
    (err_b_q && !clr_b) |=> err_b_q);
endmodule

// File: rtl/adc_trig_delay_top.sv
module adc_trig_delay_top #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  localparam int NSLOT = adc_trig_pkg::SLOT_DLY0 + 2 * NCH + 1,
  localparam int AW    = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_wdata,
  input  logic           start_evt,
  input  logic [NCH-1:0] conv_done_a,
  input  logic [NCH-1:0] conv_done_b,
  output logic [NCH-1:0] trig_a,
  output logic [NCH-1:0] trig_b,
  output logic [NCH-1:0] err_a,
  output logic [NCH-1:0] err_b,
  output logic           seq_irq
);
  import adc_trig_pkg::*;

  localparam int unsigned CLR_SLOT = errclr_slot(NCH);

  logic          cont_q;
  logic [CW-1:0] mod_q;
  logic          running;
  logic [CW-1:0] count;
  logic          clr_wr;

  assign clr_wr = cfg_we && (cfg_addr == AW'(CLR_SLOT));

  always_ff @(posedge clk) begin
    if (rst) begin
      cont_q <= 1'b0;
      mod_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == AW'(SLOT_CTRL))    cont_q <= cfg_wdata[0];
      if (cfg_addr == AW'(SLOT_MODULUS)) mod_q  <= cfg_wdata;
    end
  end

  trig_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .start   (start_evt),
    .cont    (cont_q),
    .modulus (mod_q),
    .running (running),
    .count   (count)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CW-1:0] dly_a_q, dly_b_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        dly_a_q <= '0;
        dly_b_q <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == AW'(SLOT_DLY0 + 2 * g))     dly_a_q <= cfg_wdata;
        if (cfg_addr == AW'(SLOT_DLY0 + 2 * g + 1)) dly_b_q <= cfg_wdata;
      end
    end

    trig_channel #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .running (running),
      .count   (count),
      .dly_a   (dly_a_q),
      .dly_b   (dly_b_q),
      .done_a  (conv_done_a[g]),
      .done_b  (conv_done_b[g]),
      .clr_a   (clr_wr && cfg_wdata[g]),
      .clr_b   (clr_wr && cfg_wdata[NCH + g]),
      .trig_a  (trig_a[g]),
      .trig_b  (trig_b[g]),
      .err_a   (err_a[g]),
      .err_b   (err_b[g])
    );
  end

  assign seq_irq = |{err_a, err_b};

  // R10: interrupt only drops through a clear write
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (seq_irq && !clr_wr) |=> seq_irq);
  // R11: reset leaves every flag low
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (trig_a == '0 && trig_b == '0 && !seq_irq));
endmodule

// File: tb/sim_adc_trig_delay_top.sv
module sim_adc_trig_delay_top;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int AW  = 4;
  localparam int CLR = 2 + 2 * NCH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic start_evt = 1'b0;
  logic [NCH-1:0] conv_done_a = '0, conv_done_b = '0;
  logic [NCH-1:0] trig_a, trig_b, err_a, err_b;
  logic seq_irq;

  always #4 clk = ~clk;

  adc_trig_delay_top #(.NCH(NCH), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start_evt(start_evt),
    .conv_done_a(conv_done_a), .conv_done_b(conv_done_b),
    .trig_a(trig_a), .trig_b(trig_b), .err_a(err_a), .err_b(err_b),
    .seq_irq(seq_irq)
  );

  int n_tests = 0, n_fail = 0;
  string tag = "R11";

  // Behavioural reference state
  bit m_run, m_cont;
  int m_cnt, m_mod;
  int m_da[NCH], m_db[NCH];
  bit m_ia[NCH], m_ib[NCH], m_ea[NCH], m_eb[NCH], m_ta[NCH], m_tb[NCH];
  int lat = 2;
  int cd_a[NCH], cd_b[NCH];

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_cont = 0; m_cnt = 0; m_mod = 0;
      for (int n = 0; n < NCH; n++) begin
        m_da[n] = 0; m_db[n] = 0; m_ia[n] = 0; m_ib[n] = 0;
        m_ea[n] = 0; m_eb[n] = 0; m_ta[n] = 0; m_tb[n] = 0;
      end
    end else begin
      for (int n = 0; n < NCH; n++) begin
        bit ha, hb;
        ha = m_run && (m_cnt == m_da[n]);
        hb = m_run && (m_cnt == m_db[n]);
        m_ta[n] = ha && !m_ib[n];
        m_tb[n] = hb && !m_ia[n];
        m_ea[n] = (ha && m_ib[n]) || (m_ea[n] && !(cfg_we && cfg_addr == CLR && cfg_wdata[n]));
        m_eb[n] = (hb && m_ia[n]) || (m_eb[n] && !(cfg_we && cfg_addr == CLR && cfg_wdata[NCH+n]));
        m_ia[n] = m_ta[n] || (m_ia[n] && !conv_done_a[n]);
        m_ib[n] = m_tb[n] || (m_ib[n] && !conv_done_b[n]);
      end
      if (!m_run) begin
        if (start_evt) begin m_run = 1; m_cnt = 0; end
      end else if (m_cnt == m_mod) begin
        m_cnt = 0; m_run = m_cont;
      end else m_cnt++;
      if (cfg_we) begin
        if (cfg_addr == 0) m_cont = cfg_wdata[0];
        if (cfg_addr == 1) m_mod = int'(cfg_wdata);
        for (int n = 0; n < NCH; n++) begin
          if (cfg_addr == 2 + 2*n) m_da[n] = int'(cfg_wdata);
          if (cfg_addr == 3 + 2*n) m_db[n] = int'(cfg_wdata);
        end
      end
    end
  end

  // Conversion responder: strobe done lat cycles after each model trigger
  always @(negedge clk) begin
    for (int n = 0; n < NCH; n++) begin
      conv_done_a[n] <= 1'b0;
      conv_done_b[n] <= 1'b0;
      if (cd_a[n] > 0) begin cd_a[n]--; if (cd_a[n] == 0) conv_done_a[n] <= 1'b1; end
      if (cd_b[n] > 0) begin cd_b[n]--; if (cd_b[n] == 0) conv_done_b[n] <= 1'b1; end
      if (m_ta[n]) cd_a[n] = lat;
      if (m_tb[n]) cd_b[n] = lat;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst) begin
      logic [NCH-1:0] ea, eb, ea_, eb_;
      for (int n = 0; n < NCH; n++) begin
        ea[n] = m_ta[n]; eb[n] = m_tb[n]; ea_[n] = m_ea[n]; eb_[n] = m_eb[n];
      end
      chk("trig_a (R4)", int'(trig_a), int'(ea));
      chk("trig_b (R5)", int'(trig_b), int'(eb));
      chk("err_a (R8)", int'(err_a), int'(ea_));
      chk("err_b (R8)", int'(err_b), int'(eb_));
      chk("seq_irq (R10)", int'(seq_irq), int'(|{ea_, eb_}));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = CW'(d);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); start_evt = 1'b1;
    @(negedge clk); start_evt = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired (all R) actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R11";
    chk("reset outputs R11", int'({trig_a, trig_b, err_a, err_b, seq_irq}), 0);
    idle(3);

    tag = "R12";
    wr(1, 20);
    wr(2, 2);  wr(3, 15);
    wr(4, 5);  wr(5, 17);
    wr(6, 8);  wr(7, 3);
    wr(8, 25); wr(9, 19);   // delay A of ch3 beyond modulus
    tag = "R4";
    lat = 2;
    go(); idle(30);
    tag = "R1";
    idle(20);               // one-shot: nothing more
    tag = "R3";
    go(); idle(6); go(); idle(30);

    tag = "R2";
    wr(0, 1); go(); idle(70);
    wr(0, 0); idle(30);

    tag = "R6";
    wr(CLR, 8'hFF);
    lat = 10;               // ch0: A at 2 still in flight at B=15? use 5
    wr(3, 5);
    go(); idle(30);
    tag = "R9";
    wr(CLR, 1 << NCH);      // clear err_b ch0
    idle(3);

    tag = "R7";
    wr(2, 9); wr(3, 2);     // ch0: B at 2, A at 9 inside latency
    go(); idle(30);
    wr(CLR, 1);
    idle(3);

    // Same-cycle set and clear of err_b ch0
    tag = "R9";
    wr(2, 2); wr(3, 5); wr(0, 1);
    go();
    do @(negedge clk); while (!(m_run && m_cnt == 5 && m_ia[0]));
    cfg_we = 1'b1; cfg_addr = AW'(CLR); cfg_wdata = CW'(1 << NCH);
    @(negedge clk); cfg_we = 1'b0;
    chk("err_b ch0 set wins over clear R9", int'(err_b[0]), 1);
    idle(40);
    wr(0, 0); idle(30);

    tag = "R10";
    wr(CLR, 8'hFF); idle(2);
    chk("irq low after full clear R10", int'(seq_irq), 0);

    tag = "R5";
    lat = 1; wr(1, 6); wr(0, 1);
    for (int k = 0; k < 8; k++) begin
      wr(2 + (k % 8), (k * 3) % 7);
      go(); idle(12);
    end
    wr(0, 0); idle(20);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule